// File: doc/BRIEF.md
# Bus Initiator Error Status Logic

This block sits beside the protocol engine of a bus initiator that carries one non-prefetch transaction at a time. It tracks whether such a transaction is outstanding and what kind it is, read or write. It watches the termination and parity events that the engine reports, and turns them into side effects and a set of sticky status bits.

A fatal termination ends the transaction. The fatal terminations are master abort, target abort, ready timeout and retry timeout. When one arrives on a read, the write strobe of the read-data holding register is withheld. When one arrives on a write, the request and transmit FIFOs receive a one-cycle flush. Parity trouble does not end the transaction; it is only recorded.

Two groups of sticky bits hold the record:
- an interrupt status group (fatal, parity), which is masked per bit and merged into one interrupt line;
- a configuration status group (received master abort, received target abort, detected parity error).

Software clears any of these bits by writing 1.

Top module: `bus_err_status`

## Requirements
- R1: `op_start_i` is accepted only while no transaction is outstanding, and it latches `op_is_write_i` (1 = write, 0 = read). A start while `op_busy_o` is 1 has no effect on the busy flag or on the latched type.
- R2: `op_busy_o` rises the cycle after an accepted start. It falls the cycle after `op_done_i` or any fatal termination input (`term_mabort_i`, `term_tabort_i`, `term_rdy_to_i`, `term_rty_to_i`) is seen while busy.
- R3: `rdata_we_o` is high exactly when `rdata_valid_i` is high during an outstanding read and no fatal termination input is high in that same cycle. It is never high during a write or while idle.
- R4: A fatal termination of an outstanding write makes `req_flush_o` and `tx_flush_o` high together for exactly one cycle, the cycle after the termination is seen. A fatal termination of a read causes no flush.
- R5: Any fatal termination while busy sets `irq_stat_o[0]` (fatal) on the next cycle.
- R6: A master abort while busy sets `cfg_stat_o[0]`, and a target abort while busy sets `cfg_stat_o[1]`. A timeout sets neither of them.
- R7: `rd_par_err_i` during an outstanding read sets `irq_stat_o[1]` (parity) and `cfg_stat_o[2]` (detected parity). The transaction stays outstanding.
- R8: `wr_perr_i` during an outstanding write sets `irq_stat_o[1]` only, leaves `cfg_stat_o[2]` unchanged, and does not end the transaction.
- R9: Every status bit holds until a 1 is written to its bit of `clr_irq_i` or `clr_cfg_i`. If a set and a clear arrive in the same cycle, the bit ends up set.
- R10: `irq_o` is high exactly when some bit of `irq_stat_o` is 1 while its bit of `irq_en_i` is 1.
- R11: Termination and parity inputs that arrive while no transaction is outstanding change no status bit and cause no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start_i | input | 1 | Issue a non-prefetch transaction |
| op_is_write_i | input | 1 | Type of the issued transaction, 1 = write |
| op_done_i | input | 1 | Normal completion of the transaction |
| rdata_valid_i | input | 1 | Read data valid strobe from the engine |
| term_mabort_i | input | 1 | Master abort seen |
| term_tabort_i | input | 1 | Target abort seen |
| term_rdy_to_i | input | 1 | Target ready timeout |
| term_rty_to_i | input | 1 | Retry count timeout |
| rd_par_err_i | input | 1 | Parity error detected on read data |
| wr_perr_i | input | 1 | Target signalled a parity error on write data |
| clr_irq_i | input | 2 | Write-one-to-clear for the interrupt status bits |
| clr_cfg_i | input | 3 | Write-one-to-clear for the configuration status bits |
| irq_en_i | input | 2 | Per-bit interrupt enable |
| op_busy_o | output | 1 | A transaction is outstanding |
| rdata_we_o | output | 1 | Gated write enable of the read-data holding register |
| req_flush_o | output | 1 | Flush pulse for the request FIFO |
| tx_flush_o | output | 1 | Flush pulse for the transmit FIFO |
| irq_stat_o | output | 2 | Interrupt status: bit 0 fatal, bit 1 parity |
| cfg_stat_o | output | 3 | Config status: bit 0 master abort, bit 1 target abort, bit 2 detected parity |
| irq_o | output | 1 | Masked OR of the interrupt status |

## Verification
Two pairs of functions can meet in one cycle. The first is a fatal termination that lands together with the read-data strobe. The second is a software clear that lands on the very cycle a new error sets the same bit. The bench drives a target abort on the same cycle as `rdata_valid_i`, and expects the holding-register strobe to stay low. It also drives `clr_irq_i` and `clr_cfg_i` together with a fresh master abort and a read parity error, and expects every targeted bit to read 1 on the following cycle. A behavioural model updated on every clock judges both outcomes.

// File: rtl/bes_pkg.sv
// Package bes_pkg
// Purpose : shared widths and bit positions for the bus error status block.
// Assumes : bit positions are fixed because software decodes them.
package bes_pkg;
    localparam int IRQ_W    = 2;
    localparam int CFG_W    = 3;
    localparam int TERM_W   = 4;

    localparam int IRQ_FATAL = 0;
    localparam int IRQ_PAR   = 1;

    localparam int CFG_RMA  = 0;
    localparam int CFG_RTA  = 1;
    localparam int CFG_DPE  = 2;

    localparam int TERM_MA  = 0;
    localparam int TERM_TA  = 1;
    localparam int TERM_RDY = 2;
    localparam int TERM_RTY = 3;

    typedef enum logic [1:0] {
        TXN_IDLE = 2'b00,
        TXN_RD   = 2'b01,
        TXN_WR   = 2'b10
    } txn_state_t;
endpackage

// File: rtl/bes_txn_track.sv
// Module bes_txn_track
// Purpose : tracks the single outstanding non-prefetch transaction,
//           decides when it ends, gates the read-data strobe and raises
//           the one-cycle FIFO flush after a fatal write termination.
// Assumes : at most one transaction outstanding; a start while busy is dropped.
module bes_txn_track
    import bes_pkg::*;
#(
    parameter int NTERM = TERM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_write_i,
    input  logic             done_i,
    input  logic             rvalid_i,
    input  logic [NTERM-1:0] term_i,
    output logic             busy_o,
    output logic             wr_o,
    output logic             fatal_o,
    output logic             rdata_we_o,
    output logic             flush_o
);
    txn_state_t state_q, state_d;
    logic       flush_q;
    logic       any_term;

    // Any fatal termination input present this cycle
    always_comb begin
        any_term = |term_i;
    end

    // Next transaction state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXN_IDLE: if (start_i) state_d = is_write_i ? TXN_WR : TXN_RD;
            TXN_RD,
            TXN_WR:   if (any_term || done_i) state_d = TXN_IDLE;
            default:  state_d = TXN_IDLE;
        endcase
    end

    // Transaction state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TXN_IDLE;
        else        state_q <= state_d;
    end

    // One-cycle flush after a fatal write termination
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= (state_q == TXN_WR) && any_term;
    end

    // Output decode
    always_comb begin
        busy_o     = (state_q != TXN_IDLE);
        wr_o       = (state_q == TXN_WR);
        fatal_o    = busy_o && any_term;
        rdata_we_o = (state_q == TXN_RD) && rvalid_i && !any_term;
        flush_o    = flush_q;
    end
endmodule

// File: rtl/bes_sticky_w1c.sv
// Module bes_sticky_w1c
// Purpose : bank of sticky status bits, cleared by writing one; a set in
//           the same cycle as a clear leaves the bit set.
// Assumes : set and clear are single-cycle qualified strobes.
module bes_sticky_w1c #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic bit_q;

        // Hold, clear on write-one, set has priority
        always_ff @(posedge clk) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[b]) bit_q <= 1'b1;
            else if (clr_i[b]) bit_q <= 1'b0;
        end

        assign stat_o[b] = bit_q;
    end
endmodule

// File: rtl/bes_irq_merge.sv
// Module bes_irq_merge
// Purpose : masks each interrupt status bit by its enable and ORs them.
// Assumes : purely combinational; the caller registers the status.
module bes_irq_merge #(
    parameter int W = 2
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    logic [W-1:0] masked;

    for (genvar b = 0; b < W; b++) begin : g_mask
        assign masked[b] = stat_i[b] & en_i[b];
    end

    // Merge masked sources into one line
    always_comb begin
        irq_o = |masked;
    end
endmodule

// File: rtl/bus_err_status.sv
// Module bus_err_status
// Purpose : error status logic of a bus initiator running single
//           non-prefetch transactions. Ends transactions on fatal
//           terminations, gates read data, flushes FIFOs on failed
//           writes and keeps sticky interrupt and configuration status.
// Assumes : event inputs are single-cycle qualified by the engine;
//           events seen while idle are ignored.
module bus_err_status
    import bes_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_start_i,
    input  logic             op_is_write_i,
    input  logic             op_done_i,
    input  logic             rdata_valid_i,
    input  logic             term_mabort_i,
    input  logic             term_tabort_i,
    input  logic             term_rdy_to_i,
    input  logic             term_rty_to_i,
    input  logic             rd_par_err_i,
    input  logic             wr_perr_i,
    input  logic [IRQ_W-1:0] clr_irq_i,
    input  logic [CFG_W-1:0] clr_cfg_i,
    input  logic [IRQ_W-1:0] irq_en_i,
    output logic             op_busy_o,
    output logic             rdata_we_o,
    output logic             req_flush_o,
    output logic             tx_flush_o,
    output logic [IRQ_W-1:0] irq_stat_o,
    output logic [CFG_W-1:0] cfg_stat_o,
    output logic             irq_o
);
    logic [TERM_W-1:0] term_vec;
    logic              op_wr;
    logic              fatal;
    logic              flush;
    logic [IRQ_W-1:0]  irq_set;
    logic [CFG_W-1:0]  cfg_set;

    // Gather termination events by fixed position
    always_comb begin
        term_vec           = '0;
        term_vec[TERM_MA]  = term_mabort_i;
        term_vec[TERM_TA]  = term_tabort_i;
        term_vec[TERM_RDY] = term_rdy_to_i;
        term_vec[TERM_RTY] = term_rty_to_i;
    end

    bes_txn_track #(.NTERM(TERM_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (op_start_i),
        .is_write_i (op_is_write_i),
        .done_i     (op_done_i),
        .rvalid_i   (rdata_valid_i),
        .term_i     (term_vec),
        .busy_o     (op_busy_o),
        .wr_o       (op_wr),
        .fatal_o    (fatal),
        .rdata_we_o (rdata_we_o),
        .flush_o    (flush)
    );

    // Derive status set strobes from qualified events
    always_comb begin
        irq_set            = '0;
        cfg_set            = '0;
        irq_set[IRQ_FATAL] = fatal;
        irq_set[IRQ_PAR]   = op_busy_o && ((!op_wr && rd_par_err_i) || (op_wr && wr_perr_i));
        cfg_set[CFG_RMA]   = op_busy_o && term_mabort_i;
        cfg_set[CFG_RTA]   = op_busy_o && term_tabort_i;
        cfg_set[CFG_DPE]   = op_busy_o && !op_wr && rd_par_err_i;
    end

    bes_sticky_w1c #(.W(IRQ_W)) u_irq_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .clr_i  (clr_irq_i),
        .stat_o (irq_stat_o)
    );

    bes_sticky_w1c #(.W(CFG_W)) u_cfg_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cfg_set),
        .clr_i  (clr_cfg_i),
        .stat_o (cfg_stat_o)
    );

    bes_irq_merge #(.W(IRQ_W)) u_irq (
        .stat_i (irq_stat_o),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

    // Both FIFOs flush together
    assign req_flush_o = flush;
    assign tx_flush_o  = flush;
endmodule

// File: rtl/bus_err_status_chk.sv
// Module bus_err_status_chk
// Purpose : temporal checks on the ports of bus_err_status plus the
//           latched transaction type.
// Assumes : bound to every instance of bus_err_status.
module bus_err_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_start_i,
    input logic       op_is_write_i,
    input logic       op_done_i,
    input logic       rdata_valid_i,
    input logic       term_mabort_i,
    input logic       term_tabort_i,
    input logic       term_rdy_to_i,
    input logic       term_rty_to_i,
    input logic       rd_par_err_i,
    input logic       wr_perr_i,
    input logic [1:0] clr_irq_i,
    input logic [2:0] clr_cfg_i,
    input logic [1:0] irq_en_i,
    input logic       op_busy_o,
    input logic       rdata_we_o,
    input logic       req_flush_o,
    input logic       tx_flush_o,
    input logic [1:0] irq_stat_o,
    input logic [2:0] cfg_stat_o,
    input logic       irq_o,
    input logic       op_wr
);
    logic any_term;
    assign any_term = term_mabort_i | term_tabort_i | term_rdy_to_i | term_rty_to_i;

    // R2
    busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o && any_term |=> !op_busy_o);

    // R3
    rdata_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_we_o |-> op_busy_o && !op_wr && !any_term);

    // R4
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_flush_o |=> !req_flush_o && !tx_flush_o);

    // R4
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o && op_wr && any_term |=> req_flush_o && tx_flush_o);

    // R5
    fatal_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o && any_term |=> irq_stat_o[0]);

    // R8
    wr_perr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy_o && op_wr && wr_perr_i |=> irq_stat_o[1]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stat_o[2] && !clr_cfg_i[2] |=> cfg_stat_o[2]);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |irq_stat_o);
endmodule

bind bus_err_status bus_err_status_chk chk_i (.*);

// File: tb/bus_err_status_tb_top.sv
module bus_err_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start_i = 0, op_is_write_i = 0, op_done_i = 0, rdata_valid_i = 0;
    logic       term_mabort_i = 0, term_tabort_i = 0, term_rdy_to_i = 0, term_rty_to_i = 0;
    logic       rd_par_err_i = 0, wr_perr_i = 0;
    logic [1:0] clr_irq_i = 0;
    logic [2:0] clr_cfg_i = 0;
    logic [1:0] irq_en_i = 0;
    logic       op_busy_o, rdata_we_o, req_flush_o, tx_flush_o, irq_o;
    logic [1:0] irq_stat_o;
    logic [2:0] cfg_stat_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    bit       m_busy, m_wr, m_flush;
    bit [1:0] m_irq;
    bit [2:0] m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_status dut_i (.*);

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the model for the inputs currently applied
    task automatic compare(string tag);
        bit anyt;
        anyt = term_mabort_i | term_tabort_i | term_rdy_to_i | term_rty_to_i;
        chk(tag, "op_busy_o",   op_busy_o,   m_busy);
        chk(tag, "rdata_we_o",  rdata_we_o,  m_busy && !m_wr && rdata_valid_i && !anyt);
        chk(tag, "req_flush_o", req_flush_o, m_flush);
        chk(tag, "tx_flush_o",  tx_flush_o,  m_flush);
        chk(tag, "irq_stat_o",  irq_stat_o,  m_irq);
        chk(tag, "cfg_stat_o",  cfg_stat_o,  m_cfg);
        chk(tag, "irq_o",       irq_o,       |(m_irq & irq_en_i));
    endtask

    // Advance the model by one clock using the inputs held across the edge
    task automatic model_step();
        bit anyt, fatal;
        bit [1:0] iset;
        bit [2:0] cset;
        anyt  = term_mabort_i | term_tabort_i | term_rdy_to_i | term_rty_to_i;
        fatal = m_busy && anyt;
        iset[0] = fatal;
        iset[1] = m_busy && (m_wr ? wr_perr_i : rd_par_err_i);
        cset[0] = m_busy && term_mabort_i;
        cset[1] = m_busy && term_tabort_i;
        cset[2] = m_busy && !m_wr && rd_par_err_i;
        m_irq   = (m_irq & ~clr_irq_i) | iset;
        m_cfg   = (m_cfg & ~clr_cfg_i) | cset;
        m_flush = fatal && m_wr;
        if (m_busy) begin
            if (anyt || op_done_i) m_busy = 0;
        end else if (op_start_i) begin
            m_busy = 1;
            m_wr   = op_is_write_i;
        end
    endtask

    // One cycle: apply inputs at negedge, check, cross the edge, update model
    task automatic cyc(string tag, bit st, bit wr, bit dn, bit rv,
                       bit [3:0] term, bit [1:0] par, bit [1:0] ci, bit [2:0] cc);
        op_start_i = st; op_is_write_i = wr; op_done_i = dn; rdata_valid_i = rv;
        term_mabort_i = term[0]; term_tabort_i = term[1];
        term_rdy_to_i = term[2]; term_rty_to_i = term[3];
        rd_par_err_i = par[0]; wr_perr_i = par[1];
        clr_irq_i = ci; clr_cfg_i = cc;
        #1;
        compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
    endtask

    task automatic clear_all();
        cyc("R9", 0, 0, 0, 0, 4'b0, 2'b0, 2'b11, 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        chk("R2", "reset op_busy_o", op_busy_o, 0);
        chk("R9", "reset irq_stat_o", irq_stat_o, 0);
        chk("R9", "reset cfg_stat_o", cfg_stat_o, 0);
        chk("R4", "reset req_flush_o", req_flush_o, 0);
        rst_n = 1'b1;
        irq_en_i = 2'b11;
        idle("R2", 1);

        // Plain read with data strobes, then done
        cyc("R1", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R3", 0, 0, 0, 1, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R3", 0, 0, 0, 1, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R2", 0, 0, 1, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R3", 0, 0, 0, 1, 4'b0, 2'b0, 2'b0, 3'b0);

        // Read with parity error: logged, transfer continues
        cyc("R7", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R7", 0, 0, 0, 1, 4'b0, 2'b01, 2'b0, 3'b0);
        cyc("R7", 0, 0, 0, 1, 4'b0, 2'b0, 2'b0, 3'b0);
        chk("R7", "busy after read parity", op_busy_o, 1);
        chk("R7", "dpe after read parity", cfg_stat_o[2], 1);
        cyc("R7", 0, 0, 1, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        clear_all();
        idle("R9", 1);
        chk("R9", "irq cleared", irq_stat_o, 0);

        // Write with target parity signal: parity irq only
        cyc("R8", 1, 1, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R8", 0, 0, 0, 1, 4'b0, 2'b10, 2'b0, 3'b0);
        cyc("R8", 0, 0, 0, 0, 4'b0, 2'b01, 2'b0, 3'b0);
        chk("R8", "parity irq on write", irq_stat_o[1], 1);
        chk("R8", "no dpe on write", cfg_stat_o[2], 0);
        chk("R8", "busy after write perr", op_busy_o, 1);

        // Start while busy ignored: type remains write
        cyc("R1", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        // Master abort on write: flush, fatal, rma
        cyc("R4", 0, 0, 0, 0, 4'b0001, 2'b0, 2'b0, 3'b0);
        chk("R4", "flush pulse", req_flush_o, 1);
        chk("R6", "rma set", cfg_stat_o[0], 1);
        chk("R5", "fatal set", irq_stat_o[0], 1);
        idle("R4", 2);
        clear_all();

        // Target abort on read, colliding with data strobe
        cyc("R3", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R3", 0, 0, 0, 1, 4'b0010, 2'b0, 2'b0, 3'b0);
        chk("R6", "rta set", cfg_stat_o[1], 1);
        chk("R4", "no flush on read", req_flush_o, 0);
        idle("R2", 1);
        clear_all();

        // Timeouts: fatal only, no abort bits
        cyc("R6", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R6", 0, 0, 0, 0, 4'b1000, 2'b0, 2'b0, 3'b0);
        cyc("R6", 1, 1, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R6", 0, 0, 0, 0, 4'b0100, 2'b0, 2'b0, 3'b0);
        chk("R6", "timeouts leave abort bits", cfg_stat_o[1:0], 0);
        idle("R4", 2);

        // Interrupt masking
        irq_en_i = 2'b10;
        idle("R10", 1);
        chk("R10", "fatal masked", irq_o, 0);
        irq_en_i = 2'b01;
        idle("R10", 1);
        chk("R10", "fatal enabled", irq_o, 1);
        irq_en_i = 2'b11;
        clear_all();

        // Set and clear in the same cycle: set wins
        cyc("R9", 1, 0, 0, 0, 4'b0, 2'b0, 2'b0, 3'b0);
        cyc("R9", 0, 0, 0, 0, 4'b0, 2'b01, 2'b0, 3'b0);
        cyc("R9", 0, 0, 0, 0, 4'b0001, 2'b01, 2'b11, 3'b111);
        chk("R9", "set wins irq", irq_stat_o, 3);
        chk("R9", "set wins cfg", cfg_stat_o, 5);
        clear_all();

        // Events while idle have no effect
        cyc("R11", 0, 0, 0, 1, 4'b1111, 2'b11, 2'b0, 3'b0);
        idle("R11", 1);
        chk("R11", "idle events irq", irq_stat_o, 0);
        chk("R11", "idle events cfg", cfg_stat_o, 0);
        chk("R11", "idle events flush", req_flush_o, 0);
        idle("R11", 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule